// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block turns a fixed reference clock into the oversampling enable that a UART transmitter and receiver use, one single-cycle pulse for each sixteenth of a bit. The spacing between pulses follows a divisor made of a 16-bit integer part `I` and a 6-bit fractional part `F`, with an effective value of `I + F/64`. The fraction is applied by stretching some tick periods by one reference cycle. The stretched periods are spread evenly, so any 64 consecutive periods together last exactly `64*I + F` cycles.

Software writes the integer and the fractional value into separate staging registers. Neither write alters the running rate. The staged pair becomes the active divisor only when the line-control strobe arrives. This lets both halves of a new divisor take effect together. On that strobe the period counter and the fraction accumulator restart from zero, so no shortened tick is produced. Software derives `F` by rounding the fractional part of the ideal divisor times 64. For example, a 48 MHz reference and a 921600 baud target give `I = 3` and `F = 16`. The resulting rate is about 923077 baud, roughly 0.16 % fast.

Top module: `uart_frac_tick_gen`

## Requirements
- R1: After reset the staged and the active divisor are both zero and `tick_o` stays low, even with the enable high, until a nonzero divisor is committed.
- R2: `tick_o` is high for single cycles, and any 1024 consecutive ticks span exactly `16*(64*I + F)` reference cycles, measured from one tick to the tick 1024 later.
- R3: Each gap between consecutive ticks is either `I` or `I+1` cycles, and it is always `I` when `F = 0`.
- R4: A write to the integer staging register (16 bits, `int_wdata_i`) or to the fractional staging register (6 bits, `frac_wdata_i`) does not alter the tick spacing until `lcr_wr_i` is pulsed. A staging write in the same cycle as `lcr_wr_i` is included in the commit.
- R5: When `lcr_wr_i` is high at a rising edge, the counter and accumulator restart. Counting that edge as edge 1, the first new tick is visible after edge `I+1`, and no tick appears before it.
- R6: While `en_i` is low, no tick is visible after the next rising edge and the internal state is held at zero. After `en_i` rises, counting the first edge that samples it high as edge 1, the first tick is visible after edge `I`.
- R7: An active integer divisor of 0 produces no ticks, whatever the fraction and the enable.
- R8: The full 16-bit integer range is honoured: with `I = 40000` the first period after a commit is exactly 40000 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Tick generation enable |
| int_wdata_i | input | 16 | Integer divisor value for the staging register |
| int_wr_i | input | 1 | Write strobe for the integer staging register |
| frac_wdata_i | input | 6 | Fractional divisor value (sixty-fourths) |
| frac_wr_i | input | 1 | Write strobe for the fractional staging register |
| lcr_wr_i | input | 1 | Line-control write; commits the staged divisor and restarts |
| tick_o | output | 1 | 16x oversample enable, one cycle wide |

## Verification
The bench measures long runs of 1024 ticks for several divisor pairs, including a fraction of zero, a fraction of 63 on the smallest integer, and the rounded 921600-baud pair. An accumulator that drops or double-counts a carry would miss the total by a few cycles. A stretch applied in the wrong place would show gaps outside `I` and `I+1`. Staging writes without a commit must leave the measured rate at the old value; a design that copied staging straight into the active divisor would fail this. The cycle of the first tick after a commit, after an enable rise and with a 40000-cycle integer is checked exactly. A design that did not restart would emit a runt tick, and one that truncated the integer width would produce a short first period.

// File: rtl/ubg_pkg.sv
package ubg_pkg;
    // default field widths and the oversampling ratio the divisor encodes
    localparam int UBG_INT_W   = 16;
    localparam int UBG_FRAC_W  = 6;
    localparam int UBG_OVERSMP = 16;
endpackage

// File: rtl/ubg_div_shadow.sv
module ubg_div_shadow #(
    parameter int INT_W  = ubg_pkg::UBG_INT_W,
    parameter int FRAC_W = ubg_pkg::UBG_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INT_W-1:0]  int_wdata_i,
    input  logic              int_wr_i,
    input  logic [FRAC_W-1:0] frac_wdata_i,
    input  logic              frac_wr_i,
    input  logic              lcr_wr_i,
    output logic [INT_W-1:0]  act_int_o,
    output logic [FRAC_W-1:0] act_frac_o
);
    typedef struct packed {
        logic [INT_W-1:0]  stg_int;
        logic [FRAC_W-1:0] stg_frac;
        logic [INT_W-1:0]  act_int;
        logic [FRAC_W-1:0] act_frac;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (int_wr_i)  sh_d.stg_int  = int_wdata_i;
        if (frac_wr_i) sh_d.stg_frac = frac_wdata_i;
        // the line-control write moves the whole staged pair at once
        if (lcr_wr_i) begin
            sh_d.act_int  = sh_d.stg_int;
            sh_d.act_frac = sh_d.stg_frac;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign act_int_o  = sh_q.act_int;
    assign act_frac_o = sh_q.act_frac;

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lcr_wr_i |=> ($stable(act_int_o) && $stable(act_frac_o)));
endmodule

// File: rtl/ubg_period_ctr.sv
module ubg_period_ctr #(
    parameter int INT_W  = ubg_pkg::UBG_INT_W,
    parameter int FRAC_W = ubg_pkg::UBG_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              restart_i,
    input  logic [INT_W-1:0]  div_int_i,
    input  logic [FRAC_W-1:0] div_frac_i,
    output logic              tick_o
);
    // one extra bit so a stretched period of 2**INT_W cycles still fits
    localparam int CNT_W = INT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
        logic              tick;
    } ctr_t;

    ctr_t             st_d, st_q;
    logic [FRAC_W:0]  acc_sum;
    logic             carry;
    logic             running;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        acc_sum  = {1'b0, st_q.acc} + {1'b0, div_frac_i};
        carry    = acc_sum[FRAC_W];
        running  = en_i && (div_int_i != '0);
        // a carry stretches this period by one cycle
        last_cnt = carry ? {1'b0, div_int_i} : ({1'b0, div_int_i} - CNT_W'(1));

        st_d      = st_q;
        st_d.tick = 1'b0;
        if (restart_i || !running) begin
            st_d.cnt = '0;
            st_d.acc = '0;
        end else if (st_q.cnt == last_cnt) begin
            st_d.cnt  = '0;
            st_d.acc  = acc_sum[FRAC_W-1:0];
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= {1'b0, div_int_i});
    assert_tick_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && (div_int_i > INT_W'(1))) |=> !tick_o);
    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (st_q.cnt == '0 && st_q.acc == '0 && !tick_o));
    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !tick_o);
    assert_zero_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_int_i == '0) |=> !tick_o);
endmodule

// File: rtl/uart_frac_tick_gen.sv
module uart_frac_tick_gen #(
    parameter int INT_W  = ubg_pkg::UBG_INT_W,
    parameter int FRAC_W = ubg_pkg::UBG_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [INT_W-1:0]  int_wdata_i,
    input  logic              int_wr_i,
    input  logic [FRAC_W-1:0] frac_wdata_i,
    input  logic              frac_wr_i,
    input  logic              lcr_wr_i,
    output logic              tick_o
);
    logic [INT_W-1:0]  act_int;
    logic [FRAC_W-1:0] act_frac;

    ubg_div_shadow #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_shadow (
        .clk          (clk),
        .rst_n        (rst_n),
        .int_wdata_i  (int_wdata_i),
        .int_wr_i     (int_wr_i),
        .frac_wdata_i (frac_wdata_i),
        .frac_wr_i    (frac_wr_i),
        .lcr_wr_i     (lcr_wr_i),
        .act_int_o    (act_int),
        .act_frac_o   (act_frac)
    );

    // the commit edge both loads the divisor and clears the counter
    ubg_period_ctr #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .restart_i  (lcr_wr_i),
        .div_int_i  (act_int),
        .div_frac_i (act_frac),
        .tick_o     (tick_o)
    );
endmodule

// File: tb/tb_uart_frac_tick_gen.sv
`timescale 1ns/1ps
module tb_uart_frac_tick_gen;
    localparam int WD_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic [15:0] int_wdata_i = '0;
    logic        int_wr_i = 1'b0;
    logic [5:0]  frac_wdata_i = '0;
    logic        frac_wr_i = 1'b0;
    logic        lcr_wr_i = 1'b0;
    logic        tick_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    uart_frac_tick_gen dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i),
        .int_wdata_i(int_wdata_i), .int_wr_i(int_wr_i),
        .frac_wdata_i(frac_wdata_i), .frac_wr_i(frac_wr_i),
        .lcr_wr_i(lcr_wr_i), .tick_o(tick_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WD_LIMIT) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic stage(input int iv, input int fv);
        @(negedge clk);
        int_wdata_i = 16'(iv); frac_wdata_i = 6'(fv);
        int_wr_i = 1'b1; frac_wr_i = 1'b1;
        @(negedge clk);
        int_wr_i = 1'b0; frac_wr_i = 1'b0;
    endtask

    // pulses lcr_wr_i and returns the edge index (commit edge = 1) of the first tick
    task automatic commit_first(input int limit, output int j_out);
        @(negedge clk);
        lcr_wr_i = 1'b1;
        j_out = -1;
        for (int j = 1; j <= limit; j++) begin
            @(posedge clk);
            @(negedge clk);
            lcr_wr_i = 1'b0;
            if (tick_o) begin j_out = j; break; end
        end
        lcr_wr_i = 1'b0;
    endtask

    task automatic count_ticks(input int n, output int t);
        t = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (tick_o) t++;
        end
    endtask

    // measures 1024 periods plus the gap extremes
    task automatic measure(input int iv, input int fv, input string tag);
        int c = 0, n = 0, first = 0, lastc = 0, prev = 0;
        int gmin = 1 << 30, gmax = 0;
        while (n < 1025) begin
            @(negedge clk);
            c++;
            if (tick_o) begin
                n++;
                if (n == 1) first = c;
                else begin
                    if (c - prev < gmin) gmin = c - prev;
                    if (c - prev > gmax) gmax = c - prev;
                end
                prev = c;
                if (n == 1025) lastc = c;
            end
        end
        check({"R2 total ", tag}, lastc - first, 16 * (64 * iv + fv));
        check({"R3 min gap ", tag}, gmin, (fv == 0 || fv == 63) ? iv + (fv == 63 ? 0 : 0) : iv);
        check({"R3 max gap ", tag}, gmax, (fv == 0) ? iv : iv + 1);
    endtask

    task automatic t_reset();
        int t;
        en_i = 1'b1;
        check("R1 tick low after reset", tick_o, 0);
        count_ticks(40, t);
        check("R1 no ticks with zero divisor", t, 0);
    endtask

    task automatic t_rates();
        int j;
        stage(3, 16); commit_first(100, j);
        check("R5 first tick 3/16", j, 4);
        measure(3, 16, "3/16");
        stage(1, 0); commit_first(100, j);
        check("R5 first tick 1/0", j, 2);
        measure(1, 0, "1/0");
        stage(1, 63); commit_first(100, j);
        measure(1, 63, "1/63");
        stage(5, 1); commit_first(100, j);
        measure(5, 1, "5/1");
    endtask

    task automatic t_staging();
        int j;
        stage(2, 32); commit_first(100, j);
        check("R5 first tick 2/32", j, 3);
        stage(7, 1);               // staged only, no commit
        measure(2, 32, "R4 staged-not-committed");
        // same-cycle staging write with the commit is included
        @(negedge clk);
        int_wdata_i = 16'd4; int_wr_i = 1'b1; frac_wr_i = 1'b0;
        commit_first(100, j);
        int_wr_i = 1'b0;
        check("R4 same-cycle int write committed", j, 5);
        measure(4, 1, "R4 4/1 after commit");
    endtask

    task automatic t_enable();
        int t, j;
        stage(6, 0); commit_first(100, j);
        @(negedge clk);
        en_i = 1'b0;
        count_ticks(60, t);
        check("R6 no ticks while disabled", t, 0);
        @(negedge clk);
        en_i = 1'b1;
        j = -1;
        for (int k = 1; k <= 100; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (tick_o) begin j = k; break; end
        end
        check("R6 first tick after enable", j, 6);
    endtask

    task automatic t_zero();
        int t, j;
        stage(0, 40); commit_first(100, j);
        check("R7 no tick after zero commit", j, -1);
        count_ticks(100, t);
        check("R7 zero divisor silent", t, 0);
    endtask

    task automatic t_wide();
        int j;
        stage(40000, 5); commit_first(41000, j);
        check("R8 wide integer first period", j, 40001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rates();
        t_staging();
        t_enable();
        t_zero();
        t_wide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule